// File: doc/BRIEF.md
# Mixed-Clear Interrupt Status Register

This block keeps the six interrupt status flags of a two-master bus selector and drives an active-low interrupt request toward one master. The flags fall into two groups. The first group latches short event pulses: a channel switch that happened while the bus was busy, completion of a bus recovery or initialization sequence, and a lost bus. These flags stay set until the master reads the register. The second group tracks level conditions: the external interrupt pin, this master's test-request bit, and the other master's test-request bit. A read has no effect on them. Each one clears only when its source condition goes away.

The serial interface in front of the block reports a register read as a strobe that stays high through the data phase, together with a count of the bit clocks seen so far. The read-clear fires once per read, at a configurable bit clock. A per-flag mask keeps a flag out of the interrupt request. A masked flag still shows in the status byte.

Top module: `irq_status_reg`

## Requirements
- R1: After reset every status bit is 0 and `irq_n_o` is 1. Status bits 7 and 6 always read 0.
- R2: When `sensor_evt_i` is high and `recov_req_i` is low, status bit 1 is 1 from the next cycle on. When `recov_req_i` is high, the same pulse leaves bit 1 at 0.
- R3: A pulse on `recov_done_evt_i` sets status bit 2 from the next cycle on. A pulse on `bus_lost_evt_i` does the same for status bit 3.
- R4: Status bits 1, 2 and 3 clear in the cycle after the first cycle of a read in which `rd_active_i` is 1 and `rd_bitcnt_i` equals CLEAR_AT (default 2). Earlier bit counts do not clear them.
- R5: The read-clear fires only once per read. A flag that sets later in the same read, while the count is still at CLEAR_AT, stays set. The clear re-arms once `rd_active_i` has gone low.
- R6: A set event that arrives in the same cycle as the read-clear wins, so its bit is 1 after that cycle.
- R7: Status bit 0 equals the inverse of `ext_int_n_i`, delayed by one cycle. A read does not clear it.
- R8: Status bit 4 follows `own_test_i` and status bit 5 follows `peer_test_i`, each delayed by one cycle. A read does not clear either bit.
- R9: `irq_n_o` is 0 exactly when some status bit among 5 to 0 is 1 and its `mask_i` bit is 0. Masking a bit does not change its status value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sensor_evt_i | input | 1 | Pulse: channel switched while the bus was not idle |
| recov_req_i | input | 1 | Level: a bus recovery/initialization has been requested |
| recov_done_evt_i | input | 1 | Pulse: recovery/initialization sequence completed |
| bus_lost_evt_i | input | 1 | Pulse: bus lost |
| ext_int_n_i | input | 1 | External interrupt input, active low |
| own_test_i | input | 1 | This master's test-request control bit |
| peer_test_i | input | 1 | Other master's test-request control bit |
| mask_i | input | 6 | Per-bit interrupt mask, 1 = masked |
| rd_active_i | input | 1 | High during the data phase of a status-register read |
| rd_bitcnt_i | input | CNT_W | Bit clocks counted in the current read |
| status_o | output | 8 | Status byte |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with its default parameters: CNT_W of 4 and CLEAR_AT of 2. With these values a read can be stepped one bit count at a time. That lets the bench show that counts 0 and 1 leave the flags alone, that count 2 clears them, and that holding the count at 2 does not clear a second time. The bench also drives an event into the clearing cycle, performs reads while the level sources are held asserted, and walks the mask bits, so that both clear paths and the request output are observed at the ports.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
    localparam int STAT_W   = 8;
    localparam int NFLAGS   = 6;
    localparam int NSTICKY  = 3;
    localparam int NLEVEL   = NFLAGS - NSTICKY;

    // status byte layout
    localparam int B_EXT    = 0;
    localparam int B_SENSOR = 1;
    localparam int B_RDONE  = 2;
    localparam int B_LOST   = 3;
    localparam int B_OWN    = 4;
    localparam int B_PEER   = 5;

    typedef struct packed {
        logic fired;
    } rdclr_st_t;

    typedef struct packed {
        logic flag;
    } bit_st_t;
endpackage

// File: rtl/irq_rdclr.sv
module irq_rdclr #(
    parameter int CNT_W    = 4,
    parameter int CLEAR_AT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_active_i,
    input  logic [CNT_W-1:0] rd_bitcnt_i,
    output logic             clr_o
);
    import irq_status_pkg::*;

    localparam logic [CNT_W-1:0] HIT_CNT = CNT_W'(CLEAR_AT);

    rdclr_st_t st_d, st_q;
    logic      hit;

    always_comb begin
        hit        = rd_active_i && (rd_bitcnt_i == HIT_CNT) && !st_q.fired;
        st_d       = st_q;
        // remember a fired clear until the read ends
        st_d.fired = rd_active_i ? (st_q.fired | hit) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clr_o = hit;
endmodule

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    import irq_status_pkg::*;

    bit_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // set has priority over clear
        st_d.flag = set_i | (st_q.flag & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/irq_level_bit.sv
module irq_level_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic flag_o
);
    import irq_status_pkg::*;

    bit_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int CNT_W    = 4,
    parameter int CLEAR_AT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sensor_evt_i,
    input  logic             recov_req_i,
    input  logic             recov_done_evt_i,
    input  logic             bus_lost_evt_i,
    input  logic             ext_int_n_i,
    input  logic             own_test_i,
    input  logic             peer_test_i,
    input  logic [5:0]       mask_i,
    input  logic             rd_active_i,
    input  logic [CNT_W-1:0] rd_bitcnt_i,
    output logic [7:0]       status_o,
    output logic             irq_n_o
);
    import irq_status_pkg::*;

    logic               rd_clr;
    logic [NSTICKY-1:0] sticky_set;
    logic [NSTICKY-1:0] sticky_flag;
    logic [NLEVEL-1:0]  level_src;
    logic [NLEVEL-1:0]  level_flag;
    logic [NFLAGS-1:0]  flags;

    irq_rdclr #(.CNT_W(CNT_W), .CLEAR_AT(CLEAR_AT)) u_rdclr (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_active_i (rd_active_i),
        .rd_bitcnt_i (rd_bitcnt_i),
        .clr_o       (rd_clr)
    );

    // sticky sources in order: sensor, recovery done, bus lost
    assign sticky_set[0] = sensor_evt_i & ~recov_req_i;
    assign sticky_set[1] = recov_done_evt_i;
    assign sticky_set[2] = bus_lost_evt_i;

    // level sources in order: external pin, own test, peer test
    assign level_src[0] = ~ext_int_n_i;
    assign level_src[1] = own_test_i;
    assign level_src[2] = peer_test_i;

    for (genvar gi = 0; gi < NSTICKY; gi++) begin : g_sticky
        irq_sticky_bit u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (sticky_set[gi]),
            .clr_i  (rd_clr),
            .flag_o (sticky_flag[gi])
        );
    end

    for (genvar gl = 0; gl < NLEVEL; gl++) begin : g_level
        irq_level_bit u_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (level_src[gl]),
            .flag_o  (level_flag[gl])
        );
    end

    always_comb begin
        flags           = '0;
        flags[B_EXT]    = level_flag[0];
        flags[B_SENSOR] = sticky_flag[0];
        flags[B_RDONE]  = sticky_flag[1];
        flags[B_LOST]   = sticky_flag[2];
        flags[B_OWN]    = level_flag[1];
        flags[B_PEER]   = level_flag[2];
    end

    assign status_o = {{(STAT_W-NFLAGS){1'b0}}, flags};
    assign irq_n_o  = ~|(flags & ~mask_i);
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
    parameter int CNT_W    = 4,
    parameter int CLEAR_AT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sensor_evt_i,
    input logic             recov_req_i,
    input logic             recov_done_evt_i,
    input logic             bus_lost_evt_i,
    input logic             ext_int_n_i,
    input logic [5:0]       mask_i,
    input logic             rd_active_i,
    input logic [CNT_W-1:0] rd_bitcnt_i,
    input logic [7:0]       status_o,
    input logic             irq_n_o
);
    p_sensor_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sensor_evt_i && !recov_req_i) |=> status_o[1]);

    p_sensor_suppress_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sensor_evt_i && recov_req_i && !status_o[1]) |=> !status_o[1]);

    p_done_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        recov_done_evt_i |=> status_o[2]);

    // R5: outside the clear point a set bus-lost flag holds
    p_lost_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[3] && !bus_lost_evt_i &&
         !(rd_active_i && rd_bitcnt_i == CNT_W'(CLEAR_AT))) |=> status_o[3]);

    p_ext_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_o[0] == !$past(ext_int_n_i)));

    p_all_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_i) |-> irq_n_o);

    p_top_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7:6] == 2'b00);
endmodule

bind irq_status_reg irq_status_chk #(.CNT_W(CNT_W), .CLEAR_AT(CLEAR_AT)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .sensor_evt_i     (sensor_evt_i),
    .recov_req_i      (recov_req_i),
    .recov_done_evt_i (recov_done_evt_i),
    .bus_lost_evt_i   (bus_lost_evt_i),
    .ext_int_n_i      (ext_int_n_i),
    .mask_i           (mask_i),
    .rd_active_i      (rd_active_i),
    .rd_bitcnt_i      (rd_bitcnt_i),
    .status_o         (status_o),
    .irq_n_o          (irq_n_o)
);

// File: tb/tb_irq_status_reg.sv
module tb_irq_status_reg;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sensor_evt_i = 0, recov_req_i = 0, recov_done_evt_i = 0;
    logic             bus_lost_evt_i = 0, ext_int_n_i = 1, own_test_i = 0, peer_test_i = 0;
    logic [5:0]       mask_i = '0;
    logic             rd_active_i = 0;
    logic [CNT_W-1:0] rd_bitcnt_i = '0;
    logic [7:0]       status_o;
    logic             irq_n_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    irq_status_reg #(.CNT_W(CNT_W), .CLEAR_AT(2)) dut (
        .clk(clk), .rst_n(rst_n), .sensor_evt_i(sensor_evt_i), .recov_req_i(recov_req_i),
        .recov_done_evt_i(recov_done_evt_i), .bus_lost_evt_i(bus_lost_evt_i),
        .ext_int_n_i(ext_int_n_i), .own_test_i(own_test_i), .peer_test_i(peer_test_i),
        .mask_i(mask_i), .rd_active_i(rd_active_i), .rd_bitcnt_i(rd_bitcnt_i),
        .status_o(status_o), .irq_n_o(irq_n_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic end_read();
        rd_active_i = 0; rd_bitcnt_i = '0; step();
    endtask

    task automatic full_read();
        rd_active_i = 1;
        for (int i = 0; i < 4; i++) begin rd_bitcnt_i = CNT_W'(i); step(); end
        end_read();
    endtask

    task automatic t_reset();
        chk("R1 status after reset", status_o, 8'h00);
        chk("R1 irq_n after reset", {7'b0, irq_n_o}, 8'h01);
    endtask

    task automatic t_sensor();
        sensor_evt_i = 1; step(); sensor_evt_i = 0;
        chk("R2 sensor sets bit1", status_o, 8'h02);
        chk("R9 irq asserted by bit1", {7'b0, irq_n_o}, 8'h00);
        full_read();
        chk("R4 sensor cleared by read", status_o, 8'h00);
        recov_req_i = 1; sensor_evt_i = 1; step(); sensor_evt_i = 0; step();
        chk("R2 sensor suppressed during recovery request", status_o, 8'h00);
        recov_req_i = 0; step();
    endtask

    task automatic t_read_timing();
        recov_done_evt_i = 1; bus_lost_evt_i = 1; step();
        recov_done_evt_i = 0; bus_lost_evt_i = 0;
        chk("R3 recovery-done and bus-lost set", status_o, 8'h0C);
        rd_active_i = 1; rd_bitcnt_i = 0; step();
        chk("R4 no clear at count 0", status_o, 8'h0C);
        rd_bitcnt_i = 1; step();
        chk("R4 no clear at count 1", status_o, 8'h0C);
        rd_bitcnt_i = 2; step();
        chk("R4 cleared at count 2", status_o, 8'h00);
        // R5: count held at 2, a new event stays
        bus_lost_evt_i = 1; step(); bus_lost_evt_i = 0; step();
        chk("R5 event after clear in same read kept", status_o, 8'h08);
        end_read();
        chk("R5 kept after read ends", status_o, 8'h08);
        full_read();
        chk("R5 next read clears again", status_o, 8'h00);
    endtask

    task automatic t_collide();
        bus_lost_evt_i = 1; step(); bus_lost_evt_i = 0;
        rd_active_i = 1; rd_bitcnt_i = 0; step();
        rd_bitcnt_i = 1; step();
        rd_bitcnt_i = 2; recov_done_evt_i = 1; step(); recov_done_evt_i = 0;
        chk("R6 set wins over clear, lost cleared", status_o, 8'h04);
        end_read();
        full_read();
    endtask

    task automatic t_ext();
        ext_int_n_i = 0; step();
        chk("R7 ext low sets bit0", status_o, 8'h01);
        full_read();
        chk("R7 read does not clear bit0", status_o, 8'h01);
        ext_int_n_i = 1; step();
        chk("R7 ext high clears bit0", status_o, 8'h00);
    endtask

    task automatic t_test();
        own_test_i = 1; step();
        chk("R8 own test bit4", status_o, 8'h10);
        full_read();
        chk("R8 read keeps own test", status_o, 8'h10);
        own_test_i = 0; peer_test_i = 1; step();
        chk("R8 own clears, peer sets bit5", status_o, 8'h20);
        chk("R9 irq by peer test", {7'b0, irq_n_o}, 8'h00);
        peer_test_i = 0; step();
        chk("R8 peer clears", status_o, 8'h00);
        chk("R9 irq released", {7'b0, irq_n_o}, 8'h01);
    endtask

    task automatic t_mask();
        mask_i = 6'b000001; ext_int_n_i = 0; step();
        chk("R9 masked bit still recorded", status_o, 8'h01);
        chk("R9 masked bit no irq", {7'b0, irq_n_o}, 8'h01);
        mask_i = 6'b111110; step();
        chk("R9 unmasked bit drives irq", {7'b0, irq_n_o}, 8'h00);
        ext_int_n_i = 1; mask_i = '0; step();
        chk("R1 upper bits zero", {status_o[7:6], 6'b0}, 8'h00);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(); step();
        t_reset();
        rst_n = 1; step();
        t_sensor();
        t_read_timing();
        t_collide();
        t_ext();
        t_test();
        t_mask();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule